// File: doc/BRIEF.md
# Linked-List Initialiser DMA Channel

This block is a DMA channel with no peripheral side. Software programs a top address, an entry count and a control word; the engine then fills memory with a reverse-linked chain of 32-bit words. It walks downward from the top address. Each word points at the entry just below it, and the lowest entry holds an all-ones end marker. A rendering pipeline later uses the prepared chain as a depth-sorted ordering table. When the walk finishes, the channel clears its run bit and pulses its interrupt.

Words leave through a valid/ready memory write port. A word is accepted on any rising edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the engine holds `mem_valid`, `mem_addr` and `mem_data` unchanged. The engine never drops `mem_valid` until the word has been accepted. With `mem_ready` held high, it delivers one word per clock.

The configuration port is a plain single-cycle write strobe. Writes to it are ignored while the channel is busy.

Top module: `list_init_dma`

## Requirements
- R1: After reset, `busy`, `irq` and `mem_valid` are low and `ctl_status` is zero. A control write (`cfg_sel`=2) with bit 24 high while idle starts the channel, and `busy` is high from the next cycle. A control write with bit 24 low only stores the word.
- R2: Words are written only when the started control word equals exactly 0x11000002. Any other started value writes nothing but still completes.
- R3: The number of words written equals the count register (`cfg_sel`=1, low CNT_W bits). The first word goes to the top address (`cfg_sel`=0), and each following word goes to the address 4 lower.
- R4: Every word except the last holds its own address minus 4, masked to the low 24 bits.
- R5: The last, lowest-addressed word holds 0x00FFFFFF.
- R6: Completion works as follows. `irq` is high for exactly one cycle. On the next cycle `busy` is low and bit 24 of `ctl_status` reads zero, with the other control bits kept.
- R7: A count of zero writes nothing and completes like R6.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay stable. With `mem_ready` high, one word is accepted per cycle.
- R9: Bits 31:24 of every written word are zero.
- R10: Configuration writes made while `busy` is high change neither the registers nor the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 top address, 1 count, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| ctl_status | output | 32 | Current control word (bit 24 = running) |
| busy | output | 1 | Channel active |
| irq | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Write word offered |
| mem_ready | input | 1 | Memory accepts the offered word |
| mem_addr | output | ADDR_W | Word address |
| mem_data | output | 32 | Word data |

## Verification
The bench builds the block with ADDR_W=32 and CNT_W=8. The narrow count keeps runs short, while a 32-bit address lets a top address with a non-zero upper byte show that the 24-bit mask applies to the written pointers only. The small count width also makes counts 0, 1 and a full-length stalled walk cheap to reach. A top address of 8 walks the chain down to address zero.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} walk_st_e;
  localparam logic [31:0] CTL_MAGIC  = 32'h1100_0002;
  localparam int          CTL_GO_BIT = 24;
  localparam logic [1:0]  SEL_TOP    = 2'd0;
  localparam logic [1:0]  SEL_COUNT  = 2'd1;
  localparam logic [1:0]  SEL_CTRL   = 2'd2;
endpackage

// File: rtl/ltc_regs.sv
module ltc_regs
  import ltc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  input  logic              done,
  output logic [ADDR_W-1:0] top_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [31:0]       ctrl_q,
  output logic              start,
  output logic              start_run
);
  logic wr_ok;
  assign wr_ok     = cfg_we && !busy;
  assign start     = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTL_GO_BIT];
  assign start_run = start && (cfg_wdata == CTL_MAGIC) && (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_ok) begin
        case (cfg_sel)
          SEL_TOP:   top_q   <= cfg_wdata[ADDR_W-1:0];
          SEL_COUNT: count_q <= cfg_wdata[CNT_W-1:0];
          SEL_CTRL:  ctrl_q  <= cfg_wdata;
          default:   ;
        endcase
      end
      if (done) ctrl_q[CTL_GO_BIT] <= 1'b0;
    end
  end

  // R10: registers are frozen while the walk runs
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(ctrl_q) && $stable(count_q) && $stable(top_q));
endmodule

// File: rtl/ltc_walker.sv
module ltc_walker
  import ltc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_run,
  input  logic [ADDR_W-1:0] top_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  walk_st_e                     st;
  logic [CNT_W-1:0]             rem;

  assign mem_valid = (st == ST_RUN);
  assign last      = (rem == CNT_W'(1));
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rem      <= '0;
      cur_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur_addr <= top_addr;
          rem      <= count;
          st       <= start_run ? ST_RUN : ST_DONE;
        end
        ST_RUN: if (mem_ready) begin
          if (last) st <= ST_DONE;
          else begin
            cur_addr <= cur_addr - STEP;
            rem      <= rem - CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !last |=> mem_valid && (cur_addr == $past(cur_addr) - STEP));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(cur_addr) && $stable(rem));
  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && last |=> done && !mem_valid);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

// File: rtl/ltc_wordgen.sv
module ltc_wordgen #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              last,
  output logic [DATA_W-1:0] data
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  logic [ADDR_W-1:0] below;
  logic [PTR_W-1:0]  ptr;

  assign below = cur_addr - STEP;
  assign ptr   = last ? {PTR_W{1'b1}} : below[PTR_W-1:0];
  assign data  = DATA_W'(ptr);
endmodule

// File: rtl/list_init_dma.sv
module list_init_dma
  import ltc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       ctl_status,
  output logic              busy,
  output logic              irq,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data
);
  localparam int PTR_W = 24;

  logic [ADDR_W-1:0] top_q;
  logic [CNT_W-1:0]  count_q;
  logic              start, start_run, last, done;

  ltc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .top_q(top_q),
    .count_q(count_q), .ctrl_q(ctl_status), .start(start), .start_run(start_run)
  );

  ltc_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_run(start_run),
    .top_addr(top_q), .count(count_q), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .cur_addr(mem_addr), .last(last),
    .busy(busy), .done(done)
  );

  ltc_wordgen #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_W(32)) u_gen (
    .cur_addr(mem_addr), .last(last), .data(mem_data)
  );

  assign irq = done;

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_data[31:24] == 8'h00));
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_data) && $stable(mem_addr));
  p_go_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !ctl_status[CTL_GO_BIT] && !busy);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[CTL_GO_BIT] |=> busy);
endmodule

// File: tb/sim_list_init_dma.sv
`timescale 1ns/1ps
module sim_list_init_dma;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam logic [31:0] MAGIC = 32'h1100_0002;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctl_status;
  logic busy, irq, mem_valid;
  logic mem_ready = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_data;

  int checks = 0, fails = 0, ready_mode = 0, cyc = 0;
  logic [31:0] exp_a[$], exp_d[$];
  logic hold_prev = 1'b0;
  logic [31:0] hold_a, hold_d;

  always #2.5 clk = ~clk;

  list_init_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl_status(ctl_status), .busy(busy), .irq(irq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern, driven off the sampling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 mem_ready <= (ready_mode == 0) ? 1'b1 :
                    (ready_mode == 1) ? (cyc % 3 != 1) : (cyc % 5 == 0);
  end

  // monitor: scoreboard and stall stability
  always @(negedge clk) if (rst_n) begin
    if (hold_prev) begin
      chk(mem_valid && mem_addr == hold_a && mem_data == hold_d, "R8 stall hold",
          mem_addr, hold_a);
    end
    hold_prev = mem_valid && !mem_ready;
    hold_a = mem_addr; hold_d = mem_data;
    if (mem_valid && mem_ready) begin
      chk(mem_data[31:24] == 8'h00, "R9 upper byte", mem_data, {8'h00, mem_data[23:0]});
      if (exp_a.size() == 0) chk(1'b0, "R2/R3 unexpected write", mem_addr, 32'hx);
      else begin
        logic [31:0] ea, ed;
        ea = exp_a.pop_front(); ed = exp_d.pop_front();
        chk(mem_addr == ea, "R3 address", mem_addr, ea);
        chk(mem_data == ed, (ed == 32'h00FF_FFFF) ? "R5 terminator" : "R4 pointer", mem_data, ed);
      end
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] top, input int n, input logic [31:0] ctl, input bit poke);
    int wait_c, irq_c;
    if (ctl == MAGIC)
      for (int i = 0; i < n; i++) begin
        logic [31:0] a;
        a = top - 32'(4 * i);
        exp_a.push_back(a);
        exp_d.push_back((i == n - 1) ? 32'h00FF_FFFF : ((a - 32'd4) & 32'h00FF_FFFF));
      end
    cfg(2'd0, top);
    cfg(2'd1, 32'(n));
    cfg(2'd2, ctl);
    chk(busy == 1'b1, "R1 busy after start", {31'd0, busy}, 32'd1);
    if (poke) begin
      cfg(2'd2, 32'h0000_0000);
      cfg(2'd1, 32'd1);
      chk(ctl_status == ctl, "R10 write ignored while busy", ctl_status, ctl);
    end
    wait_c = 0; irq_c = 0;
    while (!irq && wait_c < 2000) begin @(negedge clk); wait_c++; end
    chk(irq == 1'b1, "R6 irq raised", {31'd0, irq}, 32'd1);
    chk(exp_a.size() == 0, (n == 0) ? "R7 zero count" : "R3 word count",
        32'(exp_a.size()), 32'd0);
    @(negedge clk);
    chk(irq == 1'b0, "R6 irq one cycle", {31'd0, irq}, 32'd0);
    chk(busy == 1'b0, "R6 busy clear", {31'd0, busy}, 32'd0);
    chk(ctl_status == (ctl & ~32'h0100_0000), "R6 go bit cleared", ctl_status,
        ctl & ~32'h0100_0000);
    exp_a.delete(); exp_d.delete();
  endtask

  initial begin
    #10000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_valid && ctl_status == 0, "R1 reset state",
        {busy, irq, mem_valid, 29'd0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // control without go bit: stored only
    cfg(2'd2, 32'h0000_0002);
    @(negedge clk);
    chk(!busy && ctl_status == 32'h2, "R1 no start without bit 24", ctl_status, 32'h2);
    ready_mode = 0; run(32'h0000_1FFC, 5, MAGIC, 1'b0);
    ready_mode = 1; run(32'hAB00_0010, 4, MAGIC, 1'b0);
    ready_mode = 0; run(32'h0000_0008, 3, MAGIC, 1'b0);
    ready_mode = 0; run(32'h0000_4000, 1, MAGIC, 1'b0);
    ready_mode = 0; run(32'h0000_4000, 0, MAGIC, 1'b0);
    ready_mode = 0; run(32'h0000_4000, 6, 32'h0100_0002, 1'b0);
    ready_mode = 0; run(32'h0000_4000, 6, 32'h1100_0003, 1'b0);
    ready_mode = 2; run(32'h0010_0400, 20, MAGIC, 1'b1);
    ready_mode = 1; run(32'h00FF_FFFC, 255, MAGIC, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule